// File: doc/BRIEF.md
# Writeback Slot Scheduler for Mixed-Latency Issue

This block sits in the decode stage of an in-order pipeline. That pipeline has one writeback port shared by function units of different depths. Each operation class has a fixed number of cycles from leaving decode to reaching writeback. Because of this, a slow operation issued early and a fast operation issued later can both arrive at writeback in the same cycle. The block prevents that collision.

It keeps a small occupancy vector with one bit per future writeback cycle. Bit k stands for the cycle that is (k + shortest latency) cycles ahead. The whole vector advances by one position on every clock. In each cycle the block takes the class presented at decode and looks up its latency. It then tests the matching bit of the vector, already aligned to the current cycle. If that cycle is taken, the instruction stalls in decode and retries on the next cycle. If it is free, the instruction issues and the block marks that future cycle as taken.

The decode side works as a valid/ready pair, with `dec_stall` as the inverted ready. An instruction is accepted in a cycle where `dec_valid` is high and `dec_stall` is low, and `dec_issue` pulses in that cycle. While `dec_stall` is high, the source must keep `dec_valid` high and `dec_class` unchanged. The accept decision depends on the current vector and the presented class, with no extra cycle of delay.

Top module: `wb_slot_sched`

## Requirements
- R1: Reset empties the whole schedule. The first instruction presented after reset, of any class, issues in its first cycle without a stall.
- R2: `dec_stall` is high exactly when `dec_valid` is high and the writeback cycle of the presented class is already taken. `dec_issue` equals `dec_valid && !dec_stall`. With `dec_valid` low, both outputs stay low.
- R3: Class encodings and decode-to-writeback latencies (defaults) are: 2'b00 integer = 3 cycles, 2'b01 FP add = 6 cycles, 2'b10 FP multiply = 9 cycles. The spare code 2'b11 is treated exactly like integer.
- R4: An instruction that issues in cycle t with latency L takes writeback cycle t+L. A later instruction whose own latency would land on t+L stalls. For example, FP add three cycles after FP multiply stalls one cycle, and integer six cycles after FP multiply stalls one cycle.
- R5: The schedule advances one cycle per clock whether or not anything issues. A stalled instruction retries every cycle and issues in the first cycle whose writeback slot is free. For example, three back-to-back FP multiplies force a following FP add to stall three cycles.
- R6: No two issued instructions ever share a writeback cycle, and the stall count of every instruction in a mixed stream equals that of a cycle-exact reference schedule.
- R7: Idle cycles reserve nothing. Once the longest latency has elapsed with no issue, any class issues at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears the schedule |
| dec_valid | input | 1 | An instruction is waiting in decode |
| dec_class | input | 2 | Operation class of that instruction (encoding in R3) |
| dec_stall | output | 1 | Hold the instruction in decode this cycle (inverted ready) |
| dec_issue | output | 1 | The instruction leaves decode this cycle |

## Verification
The tests use isolated instructions of each class after reset and after long idle gaps. These show that the schedule starts empty and releases old slots, so a stale bit that was never cleared is exposed. Paired instructions spaced by exactly the latency difference, including the spare class code, separate a correct latency lookup from an off-by-one index. They also separate a correct lookup from a wrong mapping of the spare code. A burst of three FP multiplies followed by an FP add checks that a stall repeats for as long as the slot stays taken. A long pseudo-random mixed stream with gaps is compared cycle by cycle against a reference schedule. This stream catches shift-direction errors, misplaced reservations and any writeback collision.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  // Operation class codes presented at decode
  typedef enum logic [1:0] {
    OPC_INT  = 2'b00,
    OPC_FADD = 2'b01,
    OPC_FMUL = 2'b10,
    OPC_ALT  = 2'b11
  } op_class_e;

  function automatic int min3(input int a, input int b, input int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wbs_lat_map.sv
module wbs_lat_map
  import wbs_pkg::*;
#(
  parameter int LAT_INT  = 3,
  parameter int LAT_FADD = 6,
  parameter int LAT_FMUL = 9,
  parameter int MIN_LAT  = 3,
  parameter int IDX_W    = 3
) (
  input  logic [1:0]       cls,
  output logic [IDX_W-1:0] slot_idx
);

  localparam logic [IDX_W-1:0] IDX_INT  = IDX_W'(LAT_INT  - MIN_LAT);
  localparam logic [IDX_W-1:0] IDX_FADD = IDX_W'(LAT_FADD - MIN_LAT);
  localparam logic [IDX_W-1:0] IDX_FMUL = IDX_W'(LAT_FMUL - MIN_LAT);

  always_comb begin
    unique case (op_class_e'(cls))
      OPC_FADD: slot_idx = IDX_FADD;
      OPC_FMUL: slot_idx = IDX_FMUL;
      default:  slot_idx = IDX_INT;   // integer and spare code
    endcase
  end

endmodule

// File: rtl/wbs_slot_ring.sv
module wbs_slot_ring #(
  parameter int SPAN  = 7,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reserve,
  input  logic [IDX_W-1:0] reserve_idx,
  output logic [SPAN-1:0]  now_vec
);

  logic [SPAN-1:0] occ_q;
  logic [SPAN-1:0] occ_d;

  // Stored vector is last cycle's view; shift aligns it to this cycle.
  assign now_vec = occ_q >> 1;

  for (genvar k = 0; k < SPAN; k++) begin : g_slot
    assign occ_d[k] = now_vec[k] | (reserve && (reserve_idx == IDX_W'(k)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_d;
  end

endmodule

// File: rtl/wb_slot_sched.sv
module wb_slot_sched
  import wbs_pkg::*;
#(
  parameter int LAT_INT  = 3,
  parameter int LAT_FADD = 6,
  parameter int LAT_FMUL = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dec_valid,
  input  logic [1:0] dec_class,
  output logic       dec_stall,
  output logic       dec_issue
);

  localparam int MIN_LAT = min3(LAT_INT, LAT_FADD, LAT_FMUL);
  localparam int MAX_LAT = max3(LAT_INT, LAT_FADD, LAT_FMUL);
  localparam int SPAN    = MAX_LAT - MIN_LAT + 1;
  localparam int IDX_W   = (SPAN > 1) ? $clog2(SPAN) : 1;

  logic [IDX_W-1:0] slot_idx;
  logic [SPAN-1:0]  now_vec;
  logic             slot_busy;

  wbs_lat_map #(
    .LAT_INT (LAT_INT),
    .LAT_FADD(LAT_FADD),
    .LAT_FMUL(LAT_FMUL),
    .MIN_LAT (MIN_LAT),
    .IDX_W   (IDX_W)
  ) u_map (
    .cls     (dec_class),
    .slot_idx(slot_idx)
  );

  wbs_slot_ring #(
    .SPAN (SPAN),
    .IDX_W(IDX_W)
  ) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .reserve    (dec_issue),
    .reserve_idx(slot_idx),
    .now_vec    (now_vec)
  );

  assign slot_busy = now_vec[slot_idx];
  assign dec_stall = rst_n && dec_valid && slot_busy;
  assign dec_issue = rst_n && dec_valid && !slot_busy;

endmodule

// File: rtl/wbs_chk.sv
module wbs_chk #(
  parameter int LAT_INT  = 3,
  parameter int LAT_FADD = 6,
  parameter int LAT_FMUL = 9
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dec_valid,
  input logic [1:0] dec_class,
  input logic       dec_stall,
  input logic       dec_issue
);

  localparam int MIN_LAT = wbs_pkg::min3(LAT_INT, LAT_FADD, LAT_FMUL);
  localparam int MAX_LAT = wbs_pkg::max3(LAT_INT, LAT_FADD, LAT_FMUL);
  localparam int GAP     = MAX_LAT - MIN_LAT;

  // Cycles since the last issue, saturating; starts saturated (empty schedule)
  logic [7:0] quiet_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                quiet_cnt <= 8'hff;
    else if (dec_issue)        quiet_cnt <= 8'd1;
    else if (quiet_cnt != 8'hff) quiet_cnt <= quiet_cnt + 8'd1;
  end

  // R2
  no_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_issue && dec_stall));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_issue && !dec_stall));

  // R1
  empty_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(quiet_cnt) > GAP) |-> !dec_stall);

  if (LAT_FMUL - LAT_FADD == 3) begin : g_mf
    // R4
    fmul_fadd_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dec_issue && dec_class == 2'b10, 3) && dec_valid && dec_class == 2'b01)
        |-> dec_stall);
  end

  if (LAT_FMUL - LAT_INT == 6) begin : g_mi
    // R3
    fmul_int_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dec_issue && dec_class == 2'b10, 6) && dec_valid && dec_class[0] == dec_class[1])
        |-> dec_stall);
  end

endmodule

bind wb_slot_sched wbs_chk #(
  .LAT_INT (LAT_INT),
  .LAT_FADD(LAT_FADD),
  .LAT_FMUL(LAT_FMUL)
) u_wbs_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dec_valid(dec_valid),
  .dec_class(dec_class),
  .dec_stall(dec_stall),
  .dec_issue(dec_issue)
);

// File: tb/wb_slot_sched_bench.sv
`timescale 1ns/1ps
module wb_slot_sched_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [1:0] cl = 2'b00;
  logic       dec_stall, dec_issue;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit resv [256];
  bit wbtaken [256];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wb_slot_sched u_wb_slot_sched (
    .clk(clk), .rst_n(rst_n), .dec_valid(vld), .dec_class(cl),
    .dec_stall(dec_stall), .dec_issue(dec_issue)
  );

  function automatic int lat_of(input logic [1:0] c);
    case (c)
      2'b01:   return 6;
      2'b10:   return 9;
      default: return 3;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Per-cycle compare against the reference schedule (called at negedge)
  task automatic step_check();
    int wb;
    bit es, ei;
    wb = (cyc + lat_of(cl)) & 255;
    es = vld && resv[wb];
    ei = vld && !es;
    check(dec_stall == es, "R2/R4 stall", int'(dec_stall), int'(es));
    check(dec_issue == ei, "R2/R5 issue", int'(dec_issue), int'(ei));
    if (dec_issue) begin
      check(!wbtaken[wb], "R6 writeback collision", 1, 0);
      wbtaken[wb] = 1'b1;
    end
    if (ei) resv[wb] = 1'b1;
    resv[cyc & 255] = 1'b0;
    wbtaken[cyc & 255] = 1'b0;
  endtask

  task automatic issue_one(input logic [1:0] c, output int st);
    st = 0;
    vld = 1'b1;
    cl = c;
    forever begin
      @(negedge clk);
      step_check();
      if (dec_issue || (st > 40)) break;
      st++;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    vld = 1'b0;
  endtask

  task automatic idle(input int n);
    vld = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step_check();
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset();
    int st;
    @(negedge clk);
    check(!dec_stall && !dec_issue, "R1 outputs after reset", int'({dec_stall, dec_issue}), 0);
    issue_one(2'b10, st);
    check(st == 0, "R1 first fmul after reset", st, 0);
    idle(12);
  endtask

  task automatic t_pairs();
    int st;
    // FP add three cycles after FP multiply
    issue_one(2'b10, st); idle(2); issue_one(2'b01, st);
    check(st == 1, "R4 fadd 3 after fmul", st, 1);
    idle(12);
    // integer six cycles after FP multiply
    issue_one(2'b10, st); idle(5); issue_one(2'b00, st);
    check(st == 1, "R3 int 6 after fmul", st, 1);
    idle(12);
    // spare code behaves as integer
    issue_one(2'b10, st); idle(5); issue_one(2'b11, st);
    check(st == 1, "R3 spare code 6 after fmul", st, 1);
    idle(12);
    issue_one(2'b10, st); idle(2); issue_one(2'b11, st);
    check(st == 0, "R3 spare code 3 after fmul", st, 0);
    idle(12);
  endtask

  task automatic t_retry();
    int st;
    issue_one(2'b10, st); issue_one(2'b10, st); issue_one(2'b10, st);
    issue_one(2'b01, st);
    check(st == 3, "R5 fadd behind three fmul", st, 3);
    idle(12);
  endtask

  task automatic t_mix();
    int st, sum;
    logic [1:0] seq [7] = '{2'b10, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00};
    sum = 0;
    for (int i = 0; i < 7; i++) begin
      issue_one(seq[i], st);
      sum += st;
    end
    check(sum == 3, "R6 mixed burst stall total", sum, 3);
    idle(12);
  endtask

  task automatic t_idle_release();
    int st;
    issue_one(2'b10, st); issue_one(2'b01, st);
    idle(9);
    issue_one(2'b00, st);
    check(st == 0, "R7 int after idle", st, 0);
    idle(9);
    issue_one(2'b01, st);
    check(st == 0, "R7 fadd after idle", st, 0);
    idle(12);
  endtask

  task automatic t_stream();
    int st;
    logic [15:0] lf = 16'hace1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[6:4] == 3'd0) idle(int'(lf[8:7]) + 1);
      issue_one(lf[1:0], st);
    end
    idle(12);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_pairs();
    t_retry();
    t_mix();
    t_idle_release();
    t_stream();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule